// File: doc/BRIEF.md
# Supervisor Control/Status Word with Chip-Select Arbitration

This block is one 32-bit register in the CPU's supervisor data space. It also decides which chip select is allowed to assert in each bus cycle. The upper byte holds sticky status flags. Hardware events set these flags, and software clears them by writing a one to each flag it wants to clear. The lower 24 bits are plain control bits that software can read and write. Among the control bits are the enable for the decode-conflict bus error and a 12-bit field that places the on-chip peripheral window on a 4 KiB boundary.

On the chip-select side, the block takes the raw request vector from the address comparators, which sit outside this block. If two or more requests are active in the same cycle, the block records a decode conflict in the top status flag. It also lets through only the lowest-numbered request. When the enable bit is set, it raises a bus error in that same cycle.

Top module: `sysctl_reg`

## Requirements
- R1: After reset, every status and control bit is 0. A read of the register returns 0, `periph_base` is 0, and `bus_err` is low.
- R2: The register answers at any byte address from 0xF4 to 0xF7, all of which decode to the same word. Other addresses are ignored: writes have no effect and reads return 0. Lane strobe `bus_be[3]` selects bits 31:24, `bus_be[2]` bits 23:16, `bus_be[1]` bits 15:8 and `bus_be[0]` bits 7:0. A write changes only the bytes whose strobe is set.
- R3: An access is honoured only when `bus_fc` equals 3'b101 (supervisor data). Any other function code leaves the register unchanged, and a read with it returns 0.
- R4: Status bits 31:24 clear when a one is written to them through lane 3. Writing zero to a status bit leaves it unchanged.
- R5: Status bit 31 is set at the clock edge that ends any cycle in which two or more bits of `cs_req` are high. It then stays set until it is cleared.
- R6: When control bit 23 is 1, `bus_err` is high in exactly those cycles in which two or more requests are active. This holds even if bit 31 is already set. When control bit 23 is 0, `bus_err` stays low.
- R7: `cs_out` carries only the lowest-numbered active bit of `cs_req`, so at most one output is ever high. A lone request passes through unchanged.
- R8: Control bits 11:0 hold address bits 23:12 of the peripheral window. `periph_base` equals that field shifted left by 12, with bits 11:0 always 0.
- R9: When a conflict and a write-one-to-clear of bit 31 fall in the same cycle, bit 31 ends up set.
- R10: A high level on `evt_in[i]` sets status bit 24+i at the next clock edge. That bit stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus cycle active |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_fc | input | 3 | Function code; 3'b101 is supervisor data |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte-lane strobes, bit 3 = most significant byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not addressed |
| evt_in | input | 7 | Event pulses that set status bits 30:24 |
| cs_req | input | N_CS | Raw chip-select requests |
| cs_out | output | N_CS | Arbitrated chip selects |
| bus_err | output | 1 | Bus error on a decode conflict |
| ctl_out | output | 24 | Current control bits |
| periph_base | output | 24 | Peripheral window base address |

## Verification
The assertions assume that `cs_req` and the bus inputs change only between clock edges and are stable at each rising edge. They also assume that at most one bus access is presented per cycle. The bench drives every input on the falling edge and samples the combinational outputs a nanosecond later, which keeps each request and each access aligned to one cycle. The conflict checks place overlapping requests both with and without a concurrent clearing write, so that the set-over-clear rule is exercised at the ports.

// File: rtl/sysctl_reg.sv
module sysctl_reg #(
  parameter int ADDR_W = 24,
  parameter int N_CS = 8,
  parameter logic [23:0] REG_ADDR = 24'h0000F4,
  parameter logic [2:0] SUP_DATA_FC = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_fc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [6:0]        evt_in,
  input  logic [N_CS-1:0]   cs_req,
  output logic [N_CS-1:0]   cs_out,
  output logic              bus_err,
  output logic [23:0]       ctl_out,
  output logic [23:0]       periph_base
);
  localparam int ERR_EN_BIT = 23;
  localparam int BASE_W = 12;

  logic [7:0]  stat_q;
  logic [23:0] ctl_q;
  logic        hit, acc, wr_hit, rd_hit, conflict;
  logic [31:0] lane_mask;
  logic [7:0]  clr;

  assign hit      = bus_addr[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2];
  assign acc      = bus_sel && hit && (bus_fc == SUP_DATA_FC);
  assign wr_hit   = acc && bus_wr;
  assign rd_hit   = acc && !bus_wr;
  assign lane_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign clr      = (wr_hit && bus_be[3]) ? bus_wdata[31:24] : 8'h00;

  assign conflict = (cs_req & (cs_req - 1'b1)) != '0;
  assign cs_out   = cs_req & (~cs_req + 1'b1);
  assign bus_err  = conflict && ctl_q[ERR_EN_BIT];

  assign bus_rdata   = rd_hit ? {stat_q, ctl_q} : 32'h0;
  assign ctl_out     = ctl_q;
  assign periph_base = {ctl_q[BASE_W-1:0], {(24-BASE_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctl_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | {conflict, evt_in};
      if (wr_hit)
        ctl_q <= (ctl_q & ~lane_mask[23:0]) | (bus_wdata[23:0] & lane_mask[23:0]);
    end
  end

  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_out));
  assert_cs_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_out & ~cs_req) == '0);
  assert_cs_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req != '0) |-> (cs_out != '0));
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cs_req) > 1) |=> stat_q[7]);
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (ctl_q[ERR_EN_BIT] && $countones(cs_req) > 1));
  assert_err_every_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[ERR_EN_BIT] && $countones(cs_req) > 1) |-> bus_err);
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && hit && bus_fc == SUP_DATA_FC && bus_be[3] && bus_wdata[31]
     && $countones(cs_req) <= 1) |=> !stat_q[7]);
  assert_user_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_fc == SUP_DATA_FC) |=> $stable(ctl_out));
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[7] && !(bus_sel && bus_wr && bus_be[3] && bus_wdata[31])) |=> stat_q[7]);
endmodule

// File: tb/sysctl_reg_test.sv
module sysctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_fc = 3'b000;
  logic [23:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_in = '0;
  logic [7:0]  cs_req = '0;
  logic [7:0]  cs_out;
  logic        bus_err;
  logic [23:0] ctl_out, periph_base;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [2:0] SD = 3'b101;

  always #4 clk = ~clk;

  sysctl_reg uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_in(evt_in), .cs_req(cs_req), .cs_out(cs_out),
    .bus_err(bus_err), .ctl_out(ctl_out), .periph_base(periph_base));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic [2:0] fc);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d; bus_fc = fc;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [2:0] fc, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_fc = fc;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(24'hF4, SD, d);
    check("R1 read", d, 32'h0);
    check("R1 base", {8'h0, periph_base}, 32'h0);
    check("R1 err", {31'h0, bus_err}, 32'h0);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr(24'hF4, 4'b1111, 32'h00A55A3C, SD);
    rd(24'hF4, SD, d);
    check("R2 full write", d, 32'h00A55A3C);
    wr(24'hF6, 4'b0010, 32'hFFFFFFFF, SD);
    rd(24'hF7, SD, d);
    check("R2 byte lane", d, 32'h00A5FF3C);
    wr(24'hF8, 4'b1111, 32'h00123456, SD);
    rd(24'hF4, SD, d);
    check("R2 miss write", d, 32'h00A5FF3C);
    rd(24'hF8, SD, d);
    check("R2 miss read", d, 32'h0);
    check("R8 base", {8'h0, periph_base}, 32'h00F3C000);
    wr(24'hF4, 4'b0011, 32'h00000ABC, SD);
    check("R8 base 2", {8'h0, periph_base}, 32'h00ABC000);
  endtask

  task automatic t_space;
    logic [31:0] d;
    wr(24'hF4, 4'b1111, 32'h00111111, 3'b001);
    wr(24'hF4, 4'b1111, 32'h00222222, 3'b110);
    check("R3 user write", {8'h0, ctl_out}, 32'h00A50ABC);
    rd(24'hF4, 3'b001, d);
    check("R3 user read", d, 32'h0);
  endtask

  task automatic t_conflict;
    logic [31:0] d;
    wr(24'hF4, 4'b1111, 32'h00800000, SD);
    @(negedge clk); cs_req = 8'b1000_0000; #1;
    check("R7 lone", {24'h0, cs_out}, 32'h80);
    check("R6 lone no err", {31'h0, bus_err}, 32'h0);
    @(negedge clk); cs_req = 8'b0010_0100; #1;
    check("R7 prio", {24'h0, cs_out}, 32'h04);
    check("R6 err", {31'h0, bus_err}, 32'h1);
    @(negedge clk); cs_req = 8'b1111_0000; #1;
    check("R7 prio 2", {24'h0, cs_out}, 32'h10);
    check("R6 err again", {31'h0, bus_err}, 32'h1);
    @(negedge clk); cs_req = 0;
    rd(24'hF4, SD, d);
    check("R5 flag", d, 32'h80800000);
    wr(24'hF4, 4'b1000, 32'h00000000, SD);
    rd(24'hF4, SD, d);
    check("R4 write zero", d, 32'h80800000);
    wr(24'hF4, 4'b0111, 32'h80800000, SD);
    rd(24'hF4, SD, d);
    check("R4 lane gated", d, 32'h80800000);
    wr(24'hF4, 4'b1000, 32'h80000000, SD);
    rd(24'hF4, SD, d);
    check("R4 clear", d, 32'h00800000);
    wr(24'hF4, 4'b0100, 32'h00000000, SD);
    @(negedge clk); cs_req = 8'b0000_0011; #1;
    check("R6 disabled", {31'h0, bus_err}, 32'h0);
    @(negedge clk); cs_req = 0;
    rd(24'hF4, SD, d);
    check("R5 flag no enable", d, 32'h80000000);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(24'hF4, 4'b1000, 32'h80000000, SD);
    @(negedge clk);
    cs_req = 8'b0000_0110;
    bus_sel = 1; bus_wr = 1; bus_addr = 24'hF4; bus_be = 4'b1000;
    bus_wdata = 32'h80000000; bus_fc = SD;
    @(negedge clk);
    cs_req = 0; bus_sel = 0; bus_wr = 0; bus_be = 0;
    rd(24'hF4, SD, d);
    check("R9 set wins", d[31:24], 8'h80);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr(24'hF4, 4'b1000, 32'hFF000000, SD);
    @(negedge clk); evt_in = 7'b000_0001;
    @(negedge clk); evt_in = 0;
    rd(24'hF4, SD, d);
    check("R10 event", d[31:24], 8'h01);
    @(negedge clk); evt_in = 7'b100_0000;
    @(negedge clk); evt_in = 0;
    rd(24'hF4, SD, d);
    check("R10 sticky", d[31:24], 8'h41);
    wr(24'hF4, 4'b1000, 32'h01000000, SD);
    rd(24'hF4, SD, d);
    check("R10 clear one", d[31:24], 8'h40);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lanes();
    t_space();
    t_conflict();
    t_race();
    t_events();
    done = 1;
    finish_up();
  end
endmodule